// File: doc/BRIEF.md
# Page Translation Unit with Associative Cache and Table Walk

This block turns a 32-bit virtual address into a physical address. The upper 20 bits are the virtual page number. The lower 12 bits are the in-page offset, which passes through unchanged. An 8-slot associative cache of recent page-to-frame pairs is searched in parallel with every request. A hit answers on the next cycle and touches no memory.

On a miss the block reads one 32-bit descriptor from an in-memory table. The descriptor address is the table base plus four times the page number. It uses a single-outstanding request/ready read port for this. A usable descriptor is copied into the cache, into the slot chosen by a rotating pointer, and the translation completes. A page number at or beyond the table length, or a descriptor whose valid bit is clear, ends the request with a fault instead of a translation.

The requester presents one request at a time and waits for the done or fault pulse. A flush input discards every cached pair at once, for example after the table has been rewritten.

Top module: `vpn_xlate`

## Requirements
- R1: The physical address is the 20-bit frame number placed in bits 31:12, with bits 11:0 copied from the request's virtual address. It is valid while `xl_done` is high.
- R2: A request whose page is cached is accepted at a clock edge, and `xl_done` pulses high in the cycle right after it. `mem_req` stays low throughout.
- R3: For a request whose page is not cached, `mem_req` rises in the cycle after acceptance. `mem_addr` equals `pt_base + 4*page` and both hold until a cycle with `mem_ready` high. `mem_rdata` is taken in that cycle, and `xl_done` or `xl_fault` pulses in the next cycle.
- R4: After a successful fill, a later request to the same page is a hit (no memory read), as long as the slot has not been flushed or replaced.
- R5: A page number greater than or equal to `pt_len` gives an `xl_fault` pulse in the cycle after acceptance. No memory read is issued and the cache is unchanged. With `pt_len` of 0, every page faults.
- R6: A descriptor with bit 0 clear gives an `xl_fault` pulse and is not cached, so the same page misses again on its next request.
- R7: Descriptor format: bit 0 is the valid flag and bits 31:12 are the frame number. Bits 11:1 have no effect on the result.
- R8: Fills go to the slots in rotation: slot 0 first after reset, then 1, up to 7, then back to 0. The pointer advances only on a successful fill, and flush does not move it. A fill evicts whatever page the slot held.
- R9: A cycle with `flush` high empties the cache, so every later request misses until it is refilled. A request accepted in the same cycle as `flush` is handled as a miss.
- R10: `req_valid` is ignored while a table read is in progress. An ignored request produces no response and no fill.
- R11: Out of reset, `xl_done`, `xl_fault` and `mem_req` are low and the cache is empty.
- R12: `xl_done` and `xl_fault` are never high together, and at most one table read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all cached pairs |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address |
| pt_base | input | 32 | Byte address of descriptor table |
| pt_len | input | 21 | Number of descriptors in the table |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor byte address |
| mem_ready | input | 1 | Read data valid, ends the read |
| mem_rdata | input | 32 | Descriptor read data |
| xl_done | output | 1 | Translation complete pulse |
| xl_fault | output | 1 | Fault pulse |
| xl_paddr | output | 32 | Physical address |

## Verification
The bound checker watches these properties on every cycle:
- done and fault are mutually exclusive;
- the read port holds its request and address until ready;
- a hit answers next cycle without a read;
- an out-of-range page faults without a read;
- a miss always issues a read;
- an invalid descriptor leaves the cache untouched;
- at most one slot ever matches;
- flush empties the cache.

Only the bench's scenarios can show the rest:
- the physical address values;
- rotation order and eviction;
- a filled page turning into a later hit;
- requests ignored while busy;
- reserved descriptor bits having no effect.

The bench shows these by sweeping page numbers against an arithmetic descriptor generator and a bench-side cache model, with varied memory latency.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int PTE_VALID_BIT = 0;
  typedef enum logic {XS_IDLE, XS_FETCH} xlt_state_e;
endpackage

// File: rtl/xlt_cam.sv
module xlt_cam #(
  parameter int N     = 8,
  parameter int TAG_W = 20,
  parameter int DAT_W = 20,
  parameter int IDX_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [TAG_W-1:0]   look_tag,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [DAT_W-1:0]   wr_dat,
  output logic [N-1:0]       match_vec,
  output logic [N-1:0]       valid_vec,
  output logic [N*DAT_W-1:0] dat_flat
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    logic             vld_r;
    logic [TAG_W-1:0] tag_r;
    logic [DAT_W-1:0] dat_r;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)     vld_r <= 1'b0;
      else if (flush) vld_r <= 1'b0;
      else if (sel)   vld_r <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_r <= wr_tag;
        dat_r <= wr_dat;
      end
    end

    assign match_vec[i]             = vld_r && (tag_r == look_tag);
    assign valid_vec[i]             = vld_r;
    assign dat_flat[i*DAT_W +: DAT_W] = dat_r;
  end
endmodule

// File: rtl/xlt_ohmux.sv
module xlt_ohmux #(
  parameter int N = 8,
  parameter int W = 20
) (
  input  logic [N-1:0]   sel,
  input  logic [N*W-1:0] din_flat,
  output logic [W-1:0]   dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      dout = dout | (din_flat[i*W +: W] & {W{sel[i]}});
    end
  end
endmodule

// File: rtl/xlt_victim.sv
module xlt_victim #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)   idx <= '0;
    else if (adv) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/vpn_xlate.sv
module vpn_xlate
  import xlt_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PG_BITS = 12,
  parameter int PTE_W   = 32,
  parameter int AW      = 32,
  parameter int TLB_N   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 req_valid,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic [AW-1:0]        pt_base,
  input  logic [VA_W-PG_BITS:0] pt_len,
  output logic                 mem_req,
  output logic [AW-1:0]        mem_addr,
  input  logic                 mem_ready,
  input  logic [PTE_W-1:0]     mem_rdata,
  output logic                 xl_done,
  output logic                 xl_fault,
  output logic [PTE_W-1:0]     xl_paddr
);
  localparam int VPN_W = VA_W - PG_BITS;
  localparam int PFN_W = PTE_W - PG_BITS;
  localparam int IDX_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  // arithmetic kept in functions
  function automatic logic [AW-1:0] pte_addr_of(input logic [AW-1:0] base,
                                                input logic [VPN_W-1:0] vpn);
    logic [AW-1:0] ext;
    ext = '0;
    ext[VPN_W+1:2] = vpn;
    return base + ext;
  endfunction

  function automatic logic pte_ok(input logic [PTE_W-1:0] pte);
    return pte[PTE_VALID_BIT];
  endfunction

  function automatic logic [PFN_W-1:0] pte_pfn(input logic [PTE_W-1:0] pte);
    return pte[PTE_W-1:PG_BITS];
  endfunction

  function automatic logic [PTE_W-1:0] join_pa(input logic [PFN_W-1:0] pfn,
                                               input logic [PG_BITS-1:0] off);
    return {pfn, off};
  endfunction

  function automatic logic out_of_range(input logic [VPN_W-1:0] vpn,
                                        input logic [VPN_W:0] len);
    return {1'b0, vpn} >= len;
  endfunction

  xlt_state_e          state;
  logic [VPN_W-1:0]    vpn_q;
  logic [PG_BITS-1:0]  off_q;
  logic [AW-1:0]       addr_q;
  logic                done_q, fault_q;
  logic [PTE_W-1:0]    paddr_q;

  logic [VPN_W-1:0]    req_vpn;
  logic [PG_BITS-1:0]  req_off;
  logic [TLB_N-1:0]    match_vec, valid_vec;
  logic [TLB_N*PFN_W-1:0] pfn_flat;
  logic [PFN_W-1:0]    hit_pfn;
  logic [IDX_W-1:0]    victim_idx;

  // named internal events
  logic accept, bound_err, lookup_hit, lookup_miss, fill_done, install_en;

  assign req_vpn     = req_vaddr[VA_W-1:PG_BITS];
  assign req_off     = req_vaddr[PG_BITS-1:0];
  assign accept      = req_valid && (state == XS_IDLE);
  assign bound_err   = accept && out_of_range(req_vpn, pt_len);
  assign lookup_hit  = accept && !bound_err && !flush && (|match_vec);
  assign lookup_miss = accept && !bound_err && !lookup_hit;
  assign fill_done   = (state == XS_FETCH) && mem_ready;
  assign install_en  = fill_done && pte_ok(mem_rdata);

  xlt_cam #(.N(TLB_N), .TAG_W(VPN_W), .DAT_W(PFN_W), .IDX_W(IDX_W)) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .look_tag (req_vpn),
    .wr_en    (install_en),
    .wr_idx   (victim_idx),
    .wr_tag   (vpn_q),
    .wr_dat   (pte_pfn(mem_rdata)),
    .match_vec(match_vec),
    .valid_vec(valid_vec),
    .dat_flat (pfn_flat)
  );

  xlt_ohmux #(.N(TLB_N), .W(PFN_W)) u_mux (
    .sel     (match_vec),
    .din_flat(pfn_flat),
    .dout    (hit_pfn)
  );

  xlt_victim #(.N(TLB_N), .IDX_W(IDX_W)) u_victim (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (install_en),
    .idx  (victim_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= XS_IDLE;
      vpn_q   <= '0;
      off_q   <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      paddr_q <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (state)
        XS_IDLE: begin
          if (bound_err) begin
            fault_q <= 1'b1;
          end else if (lookup_hit) begin
            done_q  <= 1'b1;
            paddr_q <= join_pa(hit_pfn, req_off);
          end else if (lookup_miss) begin
            state  <= XS_FETCH;
            vpn_q  <= req_vpn;
            off_q  <= req_off;
            addr_q <= pte_addr_of(pt_base, req_vpn);
          end
        end
        XS_FETCH: begin
          if (fill_done) begin
            state <= XS_IDLE;
            if (pte_ok(mem_rdata)) begin
              done_q  <= 1'b1;
              paddr_q <= join_pa(pte_pfn(mem_rdata), off_q);
            end else begin
              fault_q <= 1'b1;
            end
          end
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

  assign mem_req  = (state == XS_FETCH);
  assign mem_addr = addr_q;
  assign xl_done  = done_q;
  assign xl_fault = fault_q;
  assign xl_paddr = paddr_q;
endmodule

// File: rtl/xlt_chk.sv
module xlt_chk #(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          accept,
  input logic          bound_err,
  input logic          lookup_hit,
  input logic [N-1:0]  match_vec,
  input logic [N-1:0]  valid_vec,
  input logic          mem_req,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_rdata,
  input logic          xl_done,
  input logic          xl_fault
);
  AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_done && xl_fault)); // R12
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr)); // R3
  AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |=> xl_done && !mem_req); // R2
  AST_BOUND_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bound_err |=> xl_fault && !mem_req); // R5
  AST_MISS_READS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !lookup_hit && !bound_err |=> mem_req); // R3
  AST_BAD_PTE_KEPT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready && !mem_rdata[0] && !flush
    |=> xl_fault && (valid_vec == $past(valid_vec))); // R6
  AST_MATCH_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_vec == '0); // R9
endmodule

bind vpn_xlate xlt_chk #(.N(TLB_N), .AW(AW), .DW(PTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .accept    (accept),
  .bound_err (bound_err),
  .lookup_hit(lookup_hit),
  .match_vec (match_vec),
  .valid_vec (valid_vec),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_rdata (mem_rdata),
  .xl_done   (xl_done),
  .xl_fault  (xl_fault)
);

// File: tb/sim_vpn_xlate.sv
`timescale 1ns/1ps
module sim_vpn_xlate;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        flush = 0;
  logic        req_valid = 0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] pt_base = 32'h0001_0000;
  logic [20:0] pt_len = 21'd40;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ready = 0;
  logic [31:0] mem_rdata = '0;
  logic        xl_done, xl_fault;
  logic [31:0] xl_paddr;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int wcnt = 0;
  int cyc = 0;

  logic [19:0] m_vpn [8];
  bit          m_val [8];
  int          m_rr = 0;

  always #2.5 clk = ~clk;

  vpn_xlate u0 (.*);

  // Descriptor generator: valid unless page%5==3, reserved bits scrambled (R7)
  function automatic logic [31:0] pte_of(input logic [19:0] v);
    logic [19:0] f;
    logic [10:0] junk;
    f    = v * 20'h2F1 + 20'h0A5;
    junk = v[10:0] ^ 11'h5A5;
    return {f, junk, (v % 5) != 3};
  endfunction

  // Memory responder: ready after lat wait cycles
  always @(negedge clk) begin
    cyc++;
    if (mem_ready) begin
      mem_ready = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ready = 1;
        mem_rdata = pte_of(20'((mem_addr - pt_base) >> 2));
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end else begin
      wcnt = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int m_find(input logic [19:0] v);
    for (int i = 0; i < 8; i++) if (m_val[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic m_flush();
    for (int i = 0; i < 8; i++) m_val[i] = 0;
  endtask

  // Wait for the response and check it against the model; request already accepted
  task automatic finish_req(input logic [31:0] va, input bit force_miss, input string tag);
    logic [19:0] v;
    logic [31:0] pte;
    bit bound, hit, saw_mem;
    int n;
    v = va[31:12];
    bound = {1'b0, v} >= pt_len;
    hit = !bound && !force_miss && (m_find(v) >= 0);
    pte = pte_of(v);
    saw_mem = 0;
    n = 0;
    while (!xl_done && !xl_fault && n < 40) begin
      if (mem_req) begin
        saw_mem = 1;
        chk(mem_addr == pt_base + {10'd0, v, 2'b00}, "R3", "descriptor address",
            64'(mem_addr), 64'(pt_base + {10'd0, v, 2'b00}));
      end
      @(negedge clk);
      n++;
    end
    if (bound) begin
      chk(xl_fault && !xl_done && n == 0 && !saw_mem, "R5", "bound fault {f,d,n,mem}",
          {xl_fault, xl_done, 8'(n), saw_mem}, {1'b1, 1'b0, 8'd0, 1'b0});
    end else if (hit) begin
      chk(xl_done && n == 0 && !saw_mem, "R2", "hit timing {d,n,mem}",
          {xl_done, 8'(n), saw_mem}, {1'b1, 8'd0, 1'b0});
      chk(xl_paddr == {pte[31:12], va[11:0]}, tag, "hit paddr R1",
          64'(xl_paddr), 64'({pte[31:12], va[11:0]}));
    end else begin
      chk(saw_mem, "R3", "miss reads memory", 64'(saw_mem), 64'd1);
      if (pte[0]) begin
        chk(xl_done && !xl_fault, tag, "fill done R4", {xl_done, xl_fault}, 2'b10);
        chk(xl_paddr == {pte[31:12], va[11:0]}, "R7", "fill paddr R1",
            64'(xl_paddr), 64'({pte[31:12], va[11:0]}));
        m_vpn[m_rr] = v;
        m_val[m_rr] = 1;
        m_rr = (m_rr + 1) % 8;
      end else begin
        chk(xl_fault && !xl_done, "R6", "invalid descriptor fault", {xl_fault, xl_done}, 2'b10);
      end
    end
  endtask

  task automatic xlate(input logic [31:0] va, input string tag);
    @(negedge clk);
    req_valid = 1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 0;
    finish_req(va, 0, tag);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
    m_flush();
  endtask

  function automatic logic [31:0] va_of(input logic [19:0] v);
    return {v, 12'(v * 12'h1A3 + 12'h07)};
  endfunction

  initial begin
    m_flush();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!xl_done && !xl_fault && !mem_req, "R11", "reset outputs {d,f,m}",
        {xl_done, xl_fault, mem_req}, 3'b000);
    rst_n = 1;
    @(negedge clk);
    chk(!xl_done && !xl_fault && !mem_req, "R11", "idle after reset", {xl_done, xl_fault, mem_req}, 3'b000);

    // Sweep all pages of a 40-entry table, all misses (R3, R6, R8)
    for (int v = 0; v < 40; v++) begin
      lat = v % 3;
      xlate(va_of(20'(v)), "R3");
    end
    // Revisit: recent pages hit, older ones refill (R4, R8)
    for (int v = 39; v >= 24; v--) begin
      lat = (v + 1) % 4;
      xlate(va_of(20'(v)) ^ 32'h0000_0ABC, "R4");
    end

    // Bounds (R5)
    xlate(va_of(20'd40), "R5");
    xlate(va_of(20'hFFFFF), "R5");
    pt_len = 21'd0;
    xlate(va_of(20'd0), "R5");
    pt_len = 21'h100000;
    lat = 1;
    xlate(va_of(20'hFFFFF), "R5");
    xlate(va_of(20'hFFFFF), "R4");

    // Round-robin rotation and eviction (R8)
    pt_len = 21'd200;
    do_flush();
    for (int k = 0; k < 12; k++) xlate(va_of(20'(k * 5)), "R8");
    for (int k = 0; k < 12; k++) xlate(va_of(20'(k * 5 + 1)), "R8");
    for (int k = 11; k >= 0; k--) xlate(va_of(20'(k * 5)), "R8");

    // Flush then request: miss (R9)
    xlate(va_of(20'd7), "R9");
    xlate(va_of(20'd7), "R9");
    do_flush();
    xlate(va_of(20'd7), "R9");
    // Flush in same cycle as request: handled as miss (R9)
    @(negedge clk);
    flush = 1;
    req_valid = 1;
    req_vaddr = va_of(20'd7);
    @(negedge clk);
    flush = 0;
    req_valid = 0;
    m_flush();
    finish_req(va_of(20'd7), 1, "R9");

    // Request during a table read is ignored (R10)
    lat = 3;
    @(negedge clk);
    req_valid = 1;
    req_vaddr = va_of(20'd50);
    @(negedge clk);
    req_vaddr = va_of(20'd51);
    @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    finish_req(va_of(20'd50), 0, "R10");
    begin
      bit extra;
      extra = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (xl_done || xl_fault || mem_req) extra = 1;
      end
      chk(!extra, "R10", "no response to ignored request", 64'(extra), 64'd0);
    end
    lat = 0;
    xlate(va_of(20'd51), "R10");
    xlate(va_of(20'd50), "R10");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule